// File: doc/BRIEF.md
# N-Way Tree Handshake Arbiter

This block gives one of N requesters at a time the use of a single shared resource. Each requester has a four-phase handshake port of its own, a request and an acknowledge. The resource side has one shared request, one shared acknowledge and a one-hot select vector. The data path multiplexer in front of the resource uses the select vector to pick the granted requester's payload.

Exclusion comes from a binary tree of N-1 two-input mutual-exclusion cells, so N may be any power of two from 2 up. The tree has log2(N) levels. Each cell is a small state machine with three named states:
- CELL_FREE: owned by neither side.
- CELL_LO: owned by its lower-index child.
- CELL_HI: owned by its higher-index child.

The transitions are:
- CELL_FREE to CELL_LO, taken when the lower side requests. This includes a same-cycle tie, which the lower side wins.
- CELL_FREE to CELL_HI, taken when only the higher side requests.
- CELL_LO or CELL_HI back to CELL_FREE, taken once the owning side no longer needs the cell.

A leaf side needs the cell while its requester's request or acknowledge is high. An inner side needs the cell while the child cell below it is owned. As a result, a granted requester keeps the resource through the whole handshake, including the return to zero. The acknowledge back to the requester passes through a single C-element style register stage, whatever the value of N. The design is fully synchronous and breaks ties in a fixed order in place of resolving metastability. It gives no fairness guarantee.

Top module: `tree_hs_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, sel_o, ack_o and res_req_o are all zero.
- R2: At most one bit of sel_o is ever high. Bit i of every vector belongs to requester i.
- R3: A request raised on an idle arbiter shows up as that requester's bit in sel_o exactly log2(N) clock edges after req_i rose. With N=8 this is 3 edges.
- R4: res_req_o is high exactly when the requester selected by sel_o holds its req_i high.
- R5: Once requester i is selected, sel_o stays unchanged as long as req_i[i] or ack_o[i] is high. The grant is held until the full handshake has returned to zero.
- R6: ack_o[i] rises on the edge after res_ack_i is seen high while i is selected. It falls on the edge after res_ack_i is seen low, and otherwise keeps its value. It is never high for a requester that is not selected.
- R7: When requests reach an idle arbiter in the same cycle, the lowest index wins. In every cell the lower-index side beats the higher-index side.
- R8: Every requester that follows the four-phase protocol is served in the end. A requester raises its request only after its acknowledge has fallen. Under continuous mixed traffic, no request is left stuck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Request from each requester |
| ack_o | output | N | Acknowledge to each requester |
| sel_o | output | N | One-hot select of the granted requester, for the data multiplexer |
| res_req_o | output | 1 | Request toward the shared resource |
| res_ack_i | input | 1 | Acknowledge from the shared resource |

## Verification
A cell stuck in an owned state would show within a few cycles: sel_o would stop moving and the pending requesters would never finish, which breaks the completion count under traffic. A cell that frees itself too early would, on the next clock edge, let sel_o change while a requester still holds its request or acknowledge, or it would let two select bits rise together. A wrong tie-break or an extra register in the tree would show on the very first grant, as the wrong winning index or a latency other than log2(N). A fault in the acknowledge stage would show one edge after res_ack_i changes, because the bench checks every ack_o bit against its own model on every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        CELL_FREE = 2'd0,
        CELL_LO   = 2'd1,
        CELL_HI   = 2'd2
    } cell_state_t;
endpackage

// File: rtl/mutex_cell.sv
// Two-input mutual exclusion cell. In a tie the lower side wins (R7).
// Once granted, the cell stays owned while the owner asserts keep (R5).
module mutex_cell
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_lo,
    input  logic req_hi,
    input  logic keep_lo,
    input  logic keep_hi,
    output logic grant_lo,
    output logic grant_hi
);
    cell_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CELL_FREE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            CELL_FREE: begin
                if (req_lo)      state_nxt = CELL_LO;
                else if (req_hi) state_nxt = CELL_HI;
            end
            CELL_LO:   if (!keep_lo) state_nxt = CELL_FREE;
            CELL_HI:   if (!keep_hi) state_nxt = CELL_FREE;
            default:   state_nxt = CELL_FREE;
        endcase
    end

    always_comb begin
        grant_lo = 1'b0;
        grant_hi = 1'b0;
        unique case (state)
            CELL_LO: grant_lo = 1'b1;
            CELL_HI: grant_hi = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mutex_tree.sv
// Heap-indexed binary tree of N-1 mutex cells. Node k has children 2k and 2k+1.
// Indices N..2N-1 are the leaf ports, so requester i sits at N+i.
module mutex_tree #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] take_i,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] grant_o
);
    localparam int NODES = 2 * N;

    logic [N-1:1]       g_lo, g_hi;
    logic [NODES-1:1]   path;

    assign path[1] = 1'b1;

    for (genvar k = 1; k < N; k++) begin : g_node
        logic r_lo, r_hi, k_lo, k_hi;

        if (2 * k >= N) begin : g_leaf
            assign r_lo = take_i[2 * k - N];
            assign r_hi = take_i[2 * k + 1 - N];
            assign k_lo = keep_i[2 * k - N];
            assign k_hi = keep_i[2 * k + 1 - N];
        end else begin : g_inner
            assign r_lo = g_lo[2 * k] | g_hi[2 * k];
            assign r_hi = g_lo[2 * k + 1] | g_hi[2 * k + 1];
            assign k_lo = r_lo;
            assign k_hi = r_hi;
        end

        mutex_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_lo   (r_lo),
            .req_hi   (r_hi),
            .keep_lo  (k_lo),
            .keep_hi  (k_hi),
            .grant_lo (g_lo[k]),
            .grant_hi (g_hi[k])
        );

        assign path[2 * k]     = path[k] & g_lo[k];
        assign path[2 * k + 1] = path[k] & g_hi[k];
    end

    assign grant_o = path[NODES-1:N];
endmodule

// File: rtl/ack_stage.sv
// One C-element style register per requester: it sets on a selected resource
// acknowledge, clears when the resource acknowledge is low, and holds otherwise.
module ack_stage #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sel_i,
    input  logic         res_ack_i,
    output logic [N-1:0] ack_o
);
    logic [N-1:0] ack_nxt;

    always_comb begin
        ack_nxt = (sel_i | ack_o) & {N{res_ack_i}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ack_o <= '0;
        else        ack_o <= ack_nxt;
    end
endmodule

// File: rtl/tree_hs_arbiter.sv
module tree_hs_arbiter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] ack_o,
    output logic [N-1:0] sel_o,
    output logic         res_req_o,
    input  logic         res_ack_i
);
    if ((N < 2) || ((N & (N - 1)) != 0)) begin : g_bad_n
        $error("tree_hs_arbiter: N must be a power of two of at least 2");
    end

    logic [N-1:0] keep;
    logic [N-1:0] grant;

    assign keep = req_i | ack_o;

    mutex_tree #(.N(N)) i_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (req_i),
        .keep_i  (keep),
        .grant_o (grant)
    );

    ack_stage #(.N(N)) i_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (grant),
        .res_ack_i (res_ack_i),
        .ack_o     (ack_o)
    );

    assign sel_o     = grant;
    assign res_req_o = |(grant & req_i);
endmodule

// File: rtl/tree_hs_arbiter_chk.sv
module tree_hs_arbiter_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_i,
    input logic [N-1:0] ack_o,
    input logic [N-1:0] sel_o,
    input logic         res_req_o,
    input logic         res_ack_i
);
    // R2
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // R5
    a_r5_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_o & (req_i | ack_o)) != '0) |=> (sel_o == $past(sel_o)));

    // R6
    a_r6_ack_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_o & ~sel_o) == '0));

    // R6
    a_r6_ack_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !res_ack_i |=> (ack_o == '0));

    // R6
    a_r6_ack_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ack_i && (sel_o != '0)) |=> ((ack_o & $past(sel_o)) == $past(sel_o)));

    // R4
    a_r4_idle_no_res_req: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0) |-> !res_req_o);
endmodule

bind tree_hs_arbiter tree_hs_arbiter_chk #(.N(N)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .ack_o     (ack_o),
    .sel_o     (sel_o),
    .res_req_o (res_req_o),
    .res_ack_i (res_ack_i)
);

// File: tb/test_tree_hs_arbiter.sv
`timescale 1ns/1ps
module test_tree_hs_arbiter;
    localparam int N      = 8;
    localparam int LEVELS = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] ack, sel;
    logic         res_req;
    logic         res_ack = 1'b0;

    always #4 clk = ~clk;

    tree_hs_arbiter #(.N(N)) i_tree_hs_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .ack_o     (ack),
        .sel_o     (sel),
        .res_req_o (res_req),
        .res_ack_i (res_ack)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_flag = 0;

    logic [N-1:0] want = '0;
    int issued = 0;
    int served = 0;
    int rise_cyc [N];
    int last_idx = -1;
    int last_lat = -1;
    bit arm_first = 0;
    int first_idx = -1;
    int first_lat = -1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural requesters and resource, acting on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            res_ack = res_req;
            for (int i = 0; i < N; i++) begin
                if (want[i] && !req[i] && !ack[i]) begin
                    req[i] = 1'b1;
                    want[i] = 1'b0;
                    rise_cyc[i] = cyc;
                    issued++;
                end else if (req[i] && ack[i]) begin
                    req[i] = 1'b0;
                    served++;
                end
            end
        end
    end

    // Per-clock reference comparison
    always @(posedge clk) begin
        logic [N-1:0] p_sel, p_req, p_ack, newly;
        logic         p_rack, p_rst;
        p_sel = sel; p_req = req; p_ack = ack; p_rack = res_ack; p_rst = rst_n;
        #2;
        if (p_rst && rst_n) begin
            check($countones(sel) <= 1, "R2 one-hot select", $countones(sel), 1);
            check(res_req == |(sel & req), "R4 resource request", res_req, |(sel & req));
            if ((p_sel & (p_req | p_ack)) != '0)
                check(sel == p_sel, "R5 grant held", sel, p_sel);
            for (int i = 0; i < N; i++) begin
                logic e;
                e = (p_sel[i] && p_rack) ? 1'b1 : (!p_rack ? 1'b0 : p_ack[i]);
                check(ack[i] == e, "R6 acknowledge", ack[i], e);
            end
            newly = sel & ~p_sel;
            for (int i = 0; i < N; i++) begin
                if (newly[i]) begin
                    last_idx = i;
                    last_lat = cyc - rise_cyc[i];
                    if (arm_first) begin
                        arm_first = 0;
                        first_idx = i;
                        first_lat = last_lat;
                    end
                end
            end
        end
    end

    task automatic wait_quiet();
        for (int t = 0; t < 2000; t++) begin
            @(posedge clk); #1;
            if (want == '0 && req == '0 && ack == '0 && sel == '0 && issued == served) break;
        end
        repeat (LEVELS + 3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(sel == '0, "R1 select in reset", sel, 0);
        check(ack == '0, "R1 ack in reset", ack, 0);
        check(res_req == 1'b0, "R1 res_req in reset", res_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(sel == '0 && ack == '0 && !res_req, "R1 after reset", {sel, ack}, 0);

        // R3: isolated requests on an idle arbiter
        foreach (rise_cyc[i]) rise_cyc[i] = 0;
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 0 : ((k == 1) ? 5 : 7);
            @(posedge clk); #1;
            want[p] = 1'b1;
            wait_quiet();
            check(last_idx == p, "R3 isolated winner", last_idx, p);
            check(last_lat == LEVELS, "R3 grant latency", last_lat, LEVELS);
        end

        // R7: ties on an idle arbiter, lowest index wins
        @(posedge clk); #1;
        arm_first = 1;
        want = 8'b1000_1100;
        wait_quiet();
        check(first_idx == 2, "R7 tie winner of {2,3,7}", first_idx, 2);
        check(first_lat == LEVELS, "R7 tie latency", first_lat, LEVELS);
        check(issued == served, "R8 tie set served", served, issued);

        @(posedge clk); #1;
        arm_first = 1;
        want = 8'b0110_0000;
        wait_quiet();
        check(first_idx == 5, "R7 tie winner of {5,6}", first_idx, 5);

        @(posedge clk); #1;
        arm_first = 1;
        want = 8'b1111_1111;
        wait_quiet();
        check(first_idx == 0, "R7 tie winner of all", first_idx, 0);
        check(issued == served, "R8 all served", served, issued);

        // R8: mixed continuous traffic
        for (int t = 0; t < 3000; t++) begin
            @(posedge clk); #1;
            for (int i = 0; i < N; i++)
                if (!want[i] && !req[i] && !ack[i] && ($urandom % 6 == 0)) want[i] = 1'b1;
        end
        wait_quiet();
        check(issued == served, "R8 traffic completion", served, issued);
        check(issued > 100, "R8 traffic volume", issued, 100);
        check(sel == '0 && ack == '0 && !res_req, "R4 idle after traffic", {sel, ack}, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end
endmodule